// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each incoming Ethernet frame, whether the frame should be kept, using only its 48-bit destination address. The address arrives one byte per cycle, in wire order, on a byte stream with a start strobe. The block classifies the address as unicast, multicast or broadcast. It compares the address with a programmed station address. It also folds the address through a CRC-32 to pick one bit of a 64-entry multicast hash table.

One cycle after the sixth address byte, the block emits a single-cycle result. The result carries an accept decision and the three class flags. Software programs the station address, the hash table and the accept enables through a small word-addressed write port.

Top module: `rx_addr_filter`

## Requirements
- R1: Bit 0 of the first address byte marks a group address. An all-ones group address raises only `is_bcast_o`. Any other group address raises only `is_mcast_o`. A unicast address raises neither flag.
- R2: `is_phys_o` is set exactly when the destination equals the station address. Station byte k (k = 0 is the first byte on the wire) sits at config word 0 bits [8k+7:8k] for k = 0..3. Bytes 4 and 5 sit in config word 1 bits [7:0] and [15:8].
- R3: When the physical-match enable is set, an address that matches the station is accepted.
- R4: When the broadcast enable is set, the all-ones address is accepted.
- R5: When the multicast enable is set, a multicast address is accepted only if hash table bit `crc[31:26]` is set. The CRC uses polynomial 0x04C11DB7 and starts at all ones. The bits of each byte enter LSB first, and the result is used without inversion. Hash bits 0-31 are config word 2 and bits 32-63 are config word 3.
- R6: When the accept-all enable is set, every address is accepted.
- R7: An address is accepted only for one of the reasons in R3-R6. With a reason absent, `accept_o` is 0.
- R8: `res_valid_o` is a one-cycle pulse in the cycle after the sixth byte is taken. The result flags are 0 whenever `res_valid_o` is 0.
- R9: `byte_first_i` with `byte_valid_i` starts a new address at any time and discards a partial one. Idle cycles between bytes are allowed. Bytes after the sixth that come without a new start are ignored.
- R10: Reset clears the station address, the hash table and all enables, so nothing is accepted until software programs the block.
- R11: Config word 4 holds the enables: bit 0 accept-all, bit 1 physical match, bit 2 multicast, bit 3 broadcast. Writes take effect for results whose sixth byte comes at least one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 3 | Config word index |
| cfg_wdata_i | input | 32 | Config write data |
| byte_valid_i | input | 1 | Address byte present |
| byte_first_i | input | 1 | This byte is the first of an address |
| byte_data_i | input | 8 | Address byte |
| res_valid_o | output | 1 | Result pulse |
| accept_o | output | 1 | Frame accepted |
| is_bcast_o | output | 1 | Address is broadcast |
| is_mcast_o | output | 1 | Address is multicast (non-broadcast group) |
| is_phys_o | output | 1 | Address equals station address |

## Verification
The bench drives unicast addresses that equal the station address or differ from it in a single byte. This separates the match path from the byte ordering of the station words. It drives broadcast and multicast addresses whose hash index falls in each half of the table. Each is tried with only its own bit set and then with every other bit set, which exposes CRC or index errors. Accept-all, all enables off, a restart in the middle of an address, idle gaps between bytes, and trailing extra bytes round the set out. The gap, restart and trailing-byte cases separate byte sequencing from the decision logic.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  localparam int BYTE_W = 8;
  localparam logic [31:0] CRC_POLY_DEF = 32'h04C11DB7;

  typedef struct packed {
    logic bcast_en;
    logic mcast_en;
    logic phys_en;
    logic promisc;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Serial CRC step over one byte, LSB first, no final inversion.
  function automatic logic [31:0] crc_byte(input logic [31:0] c,
                                           input logic [7:0]  d,
                                           input logic [31:0] poly);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_filt_cfg.sv
module rx_filt_cfg
  import rx_filt_pkg::*;
#(
  parameter int HASH_IDX_W = 6,
  parameter int CFG_AW     = 3,
  parameter int MAC_W      = 48
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [CFG_AW-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic [MAC_W-1:0]           station_o,
  output logic [(1<<HASH_IDX_W)-1:0] hash_o,
  output ctrl_t                      ctrl_o
);
  localparam int HASH_N     = 1 << HASH_IDX_W;
  localparam int HASH_WORDS = (HASH_N + 31) / 32;
  localparam int STA_HI_W   = MAC_W - 32;
  localparam int HASH_BASE  = 2;
  localparam int CTRL_IDX   = HASH_BASE + HASH_WORDS;

  logic [31:0]         sta_lo_q;
  logic [STA_HI_W-1:0] sta_hi_q;
  logic [HASH_WORDS*32-1:0] hash_q;
  ctrl_t               ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      ctrl_q   <= '0;
    end else if (we_i) begin
      if (addr_i == CFG_AW'(0)) sta_lo_q <= wdata_i;
      if (addr_i == CFG_AW'(1)) sta_hi_q <= wdata_i[STA_HI_W-1:0];
      if (addr_i == CFG_AW'(CTRL_IDX)) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      hash_q[32*w +: 32] <= '0;
      else if (we_i && addr_i == CFG_AW'(HASH_BASE + w)) hash_q[32*w +: 32] <= wdata_i;
    end
  end

  assign station_o = {sta_hi_q, sta_lo_q};
  assign hash_o    = hash_q[HASH_N-1:0];
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/rx_filt_collect.sv
module rx_filt_collect
  import rx_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic                         first_i,
  input  logic [BYTE_W-1:0]            data_i,
  output logic                         take_o,
  output logic                         last_o,
  output logic [ADDR_BYTES*BYTE_W-1:0] addr_o
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  logic                         busy_q;
  logic [CNT_W-1:0]             cnt_q, idx;
  logic [ADDR_BYTES*BYTE_W-1:0] addr_q;

  assign take_o = valid_i && (first_i || busy_q);
  assign idx    = first_i ? '0 : cnt_q;
  assign last_o = take_o && (idx == LAST_IDX);

  // Address with the incoming byte merged in, so the decision needs no extra cycle.
  always_comb begin
    addr_o = addr_q;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (take_o && idx == CNT_W'(i)) addr_o[BYTE_W*i +: BYTE_W] = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (take_o) begin
      busy_q <= !last_o;
      cnt_q  <= idx + CNT_W'(1);
      addr_q <= addr_o;
    end
  end
endmodule

// File: rtl/rx_filt_crc.sv
module rx_filt_crc
  import rx_filt_pkg::*;
#(
  parameter logic [31:0] POLY = CRC_POLY_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              restart_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [31:0]       crc_next_o
);
  logic [31:0] crc_q, base;

  assign base       = restart_i ? '1 : crc_q;
  assign crc_next_o = crc_byte(base, data_i, POLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (step_i) crc_q <= crc_next_o;
  end
endmodule

// File: rtl/rx_filt_decide.sv
module rx_filt_decide
  import rx_filt_pkg::*;
#(
  parameter int MAC_W      = 48,
  parameter int HASH_IDX_W = 6
) (
  input  logic [MAC_W-1:0]           addr_i,
  input  logic [MAC_W-1:0]           station_i,
  input  logic [(1<<HASH_IDX_W)-1:0] hash_i,
  input  logic [31:0]                crc_i,
  input  ctrl_t                      ctrl_i,
  output logic                       accept_o,
  output logic                       bcast_o,
  output logic                       mcast_o,
  output logic                       phys_o
);
  logic                  group, hash_hit;
  logic [HASH_IDX_W-1:0] hidx;

  assign group    = addr_i[0];
  assign bcast_o  = &addr_i;
  assign mcast_o  = group && !bcast_o;
  assign phys_o   = (addr_i == station_i);
  assign hidx     = crc_i[31 -: HASH_IDX_W];
  assign hash_hit = hash_i[hidx];

  assign accept_o = ctrl_i.promisc
                 || (ctrl_i.phys_en  && phys_o)
                 || (ctrl_i.bcast_en && bcast_o)
                 || (ctrl_i.mcast_en && mcast_o && hash_hit);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_IDX_W = 6,
  parameter logic [31:0] CRC_POLY   = CRC_POLY_DEF,
  parameter int          CFG_AW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              byte_valid_i,
  input  logic              byte_first_i,
  input  logic [7:0]        byte_data_i,
  output logic              res_valid_o,
  output logic              accept_o,
  output logic              is_bcast_o,
  output logic              is_mcast_o,
  output logic              is_phys_o
);
  localparam int MAC_W  = ADDR_BYTES * BYTE_W;
  localparam int HASH_N = 1 << HASH_IDX_W;

  logic [MAC_W-1:0]  station, addr_full;
  logic [HASH_N-1:0] hash_tbl;
  ctrl_t             ctrl_q;
  logic              take, last;
  logic [31:0]       crc_next;
  logic              d_acc, d_bc, d_mc, d_ph;
  logic              valid_q, acc_q, bc_q, mc_q, ph_q;

  rx_filt_cfg #(.HASH_IDX_W(HASH_IDX_W), .CFG_AW(CFG_AW), .MAC_W(MAC_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .station_o(station), .hash_o(hash_tbl), .ctrl_o(ctrl_q)
  );

  rx_filt_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
    .clk_i, .rst_ni,
    .valid_i(byte_valid_i), .first_i(byte_first_i), .data_i(byte_data_i),
    .take_o(take), .last_o(last), .addr_o(addr_full)
  );

  rx_filt_crc #(.POLY(CRC_POLY)) u_crc (
    .clk_i, .rst_ni,
    .step_i(take), .restart_i(byte_first_i), .data_i(byte_data_i),
    .crc_next_o(crc_next)
  );

  rx_filt_decide #(.MAC_W(MAC_W), .HASH_IDX_W(HASH_IDX_W)) u_decide (
    .addr_i(addr_full), .station_i(station), .hash_i(hash_tbl),
    .crc_i(crc_next), .ctrl_i(ctrl_q),
    .accept_o(d_acc), .bcast_o(d_bc), .mcast_o(d_mc), .phys_o(d_ph)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
      bc_q    <= 1'b0;
      mc_q    <= 1'b0;
      ph_q    <= 1'b0;
    end else begin
      valid_q <= last;
      acc_q   <= last && d_acc;
      bc_q    <= last && d_bc;
      mc_q    <= last && d_mc;
      ph_q    <= last && d_ph;
    end
  end

  assign res_valid_o = valid_q;
  assign accept_o    = acc_q;
  assign is_bcast_o  = bc_q;
  assign is_mcast_o  = mc_q;
  assign is_phys_o   = ph_q;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
  import rx_filt_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  byte_valid_i,
  input ctrl_t ctrl_i,
  input logic  res_valid_o,
  input logic  accept_o,
  input logic  is_bcast_o,
  input logic  is_mcast_o,
  input logic  is_phys_o
);
  AST_CLASS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !(is_bcast_o && is_mcast_o)); // R1

  AST_PROMISC_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(ctrl_i.promisc)) |-> accept_o); // R6

  AST_ACCEPT_REASON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && accept_o) |-> ($past(ctrl_i.promisc)
      || ($past(ctrl_i.phys_en) && is_phys_o)
      || ($past(ctrl_i.bcast_en) && is_bcast_o)
      || ($past(ctrl_i.mcast_en) && is_mcast_o))); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !(accept_o || is_bcast_o || is_mcast_o || is_phys_o)); // R8

  AST_RESULT_FROM_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(byte_valid_i)); // R9
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i), .ctrl_i(ctrl_q),
  .res_valid_o(res_valid_o), .accept_o(accept_o), .is_bcast_o(is_bcast_o),
  .is_mcast_o(is_mcast_o), .is_phys_o(is_phys_o)
);

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic bv = 1'b0, bf = 1'b0;
  logic [7:0] bd = '0;
  logic res_valid_o, accept_o, is_bcast_o, is_mcast_o, is_phys_o;

  always #2 clk = ~clk;

  rx_addr_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .byte_valid_i(bv), .byte_first_i(bf), .byte_data_i(bd),
    .res_valid_o(res_valid_o), .accept_o(accept_o), .is_bcast_o(is_bcast_o),
    .is_mcast_o(is_mcast_o), .is_phys_o(is_phys_o)
  );

  typedef struct { logic [3:0] f; string tag; } exp_t; // f = {acc,bc,mc,ph}
  exp_t sb[$];
  int n_chk = 0, n_err = 0;

  logic [47:0] m_sta = '0;
  logic [63:0] m_hash = '0;
  logic [3:0]  m_ctrl = '0; // {bcast, mcast, phys, promisc}

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[31] ^ a[8*k+i];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c;
  endfunction

  function automatic int hidx(input logic [47:0] a);
    logic [31:0] c = ref_crc(a);
    return int'(c[31:26]);
  endfunction

  function automatic logic [3:0] ref_res(input logic [47:0] a);
    logic bc, mc, ph, acc;
    bc  = &a;
    mc  = a[0] && !bc;
    ph  = (a == m_sta);
    acc = m_ctrl[0] || (m_ctrl[1] && ph) || (m_ctrl[3] && bc) ||
          (m_ctrl[2] && mc && m_hash[hidx(a)]);
    return {acc, bc, mc, ph};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      3'd0: m_sta[31:0]   = d;
      3'd1: m_sta[47:32]  = d[15:0];
      3'd2: m_hash[31:0]  = d;
      3'd3: m_hash[63:32] = d;
      3'd4: m_ctrl        = d[3:0];
      default: ;
    endcase
  endtask

  task automatic drive_byte(input logic first, input logic [7:0] d);
    @(negedge clk);
    bv = 1'b1; bf = first; bd = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bv = 1'b0; bf = 1'b0;
    end
  endtask

  // Byte k of the address is a[8k+7:8k], sent first for k = 0.
  task automatic send(input logic [47:0] a, input string tag, input int gap = 0);
    exp_t e;
    e.f = ref_res(a); e.tag = tag;
    sb.push_back(e);
    for (int k = 0; k < 6; k++) begin
      drive_byte(k == 0, a[8*k +: 8]);
      if (gap > 0 && k < 5) idle(gap);
    end
    @(negedge clk);
    bv = 1'b0; bf = 1'b0;
    check(res_valid_o === 1'b1, "R8", "pulse one cycle after sixth byte", 32'(res_valid_o), 1);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid_o) begin
        if (sb.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R9 unexpected result actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({accept_o, is_bcast_o, is_mcast_o, is_phys_o} === e.f, e.tag,
                "{acc,bc,mc,ph}", 32'({accept_o, is_bcast_o, is_mcast_o, is_phys_o}), 32'(e.f));
        end
      end else if (accept_o || is_bcast_o || is_mcast_o || is_phys_o) begin
        n_chk++; n_err++;
        $display("FAIL R8 flags without pulse actual=%b expected=0000",
                 {accept_o, is_bcast_o, is_mcast_o, is_phys_o});
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] sta, mlo, mhi, uc;
    int ilo, ihi;
    sta = 48'h66_55_44_33_22_02; // wire order 02 22 33 44 55 66
    uc  = 48'h10_20_30_40_50_60;
    mlo = '0; mhi = '0; ilo = -1; ihi = -1;
    for (int k = 0; k < 256; k++) begin
      logic [47:0] a;
      a = {8'(k), 32'h00_00_5E_00, 8'h01};
      if (hidx(a) < 32 && ilo < 0) begin mlo = a; ilo = hidx(a); end
      if (hidx(a) >= 32 && ihi < 0) begin mhi = a; ihi = hidx(a); end
    end

    repeat (3) @(negedge clk);
    check(res_valid_o === 1'b0 && accept_o === 1'b0, "R10", "outputs in reset", 32'({res_valid_o, accept_o}), 0);
    rst_n = 1'b1;
    idle(2);

    // Reset state: nothing accepted, classification still reported
    send('1, "R10");
    send(uc, "R10");
    send(48'h0, "R10"); // matches cleared station but enable is off
    cfg_wr(3'd4, 32'h4);
    send(mlo, "R10");    // hash table cleared
    cfg_wr(3'd4, 32'h0);

    // Station match and byte order
    cfg_wr(3'd0, sta[31:0]);
    cfg_wr(3'd1, {16'h0, sta[47:32]});
    send(sta, "R2");
    cfg_wr(3'd4, 32'h2);
    send(sta, "R3");
    send(sta ^ 48'h01_00_00_00_00_00, "R3"); // last byte differs
    send(sta ^ 48'h00_00_00_00_04_00, "R2");
    send({sta[7:0], sta[47:8]}, "R2");     // rotated order
    send(uc, "R7");

    // Broadcast
    send('1, "R7");
    cfg_wr(3'd4, 32'h8);
    send('1, "R4");
    send(sta, "R7");

    // Multicast hash in both halves
    cfg_wr(3'd4, 32'h4);
    cfg_wr(3'd2, 32'(1) << ilo);
    send(mlo, "R5");
    send(mhi, "R5");
    cfg_wr(3'd2, ~(32'(1) << ilo));
    send(mlo, "R5");
    cfg_wr(3'd2, 32'h0);
    cfg_wr(3'd3, 32'(1) << (ihi - 32));
    send(mhi, "R5");
    send(mlo, "R5");
    cfg_wr(3'd3, ~(32'(1) << (ihi - 32)));
    send(mhi, "R5");
    send('1, "R1");
    send(uc, "R1");

    // Accept-all
    cfg_wr(3'd4, 32'h1);
    send(uc, "R6");
    send(mhi, "R6");
    cfg_wr(3'd4, 32'hE);
    send(uc, "R11");
    send('1, "R11");

    // Sequencing: gaps, restart, trailing bytes
    send(sta, "R9", 2);
    drive_byte(1'b1, 8'hAA);
    drive_byte(1'b0, 8'hBB);
    drive_byte(1'b0, 8'hCC);
    send(sta, "R9");
    drive_byte(1'b0, 8'h11);
    drive_byte(1'b0, 8'h22);
    idle(4);
    check(sb.size() == 0, "R9", "trailing bytes made no result", 32'(sb.size()), 0);
    send(uc, "R9");

    idle(4);
    check(sb.size() == 0, "R8", "all results seen", 32'(sb.size()), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule